// File: doc/BRIEF.md
# Serial Result Port for a Read-Only Converter

This block is the digital output side of a 24-bit converter that the host can only read. While the active-low select input is held low, a built-in conversion timer finishes one conversion every `conv_period` system clocks. Each finished conversion yields a test word from a fixed arithmetic sequence. The port presents that word on a single line that carries both the ready flag and the serial data. That line idles high. It drops low when a word is waiting, and then shifts the word out one bit per serial clock.

The serial clock comes from one of two places, chosen by `mode_sel`. With `mode_sel` low, the block drives the clock itself, at the system clock divided by `CLK_DIV`. With `mode_sel` high, the host supplies the clock, and may split the 24 pulses into several bursts. Raising the select input aborts everything: the conversion stops, the held word is dropped and both outputs stop driving. A new result is never loaded while a read is in progress. It waits until the read is over, and the line is forced high for a short window before each load.

`sel_n`, `mode_sel` and `conv_period` are sampled in the system clock domain. `sclk_in` passes through a two-stage synchronizer.

Top module: `serial_result_port`

## Requirements
- R1: With `sel_n` high, `dout_oe` and `sclk_oe` are 0 and `sclk_out` is 1. The held word and the conversion count are cleared, so the first word after `sel_n` falls again has index 0, and the line stays high until that word arrives.
- R2: While selected, conversion n (n = 0, 1, ...) completes every `conv_period` cycles. Its word is `SEED + n*STEP` modulo 2^24. The line first reads low at the `conv_period + 3`-th clock after `sel_n` falls.
- R3: While no word is waiting, the data line is 1 and the generated clock stays at 1. A loaded word pulls the line to 0.
- R4: Before each load the line is forced high for exactly `BLANK_CYC` cycles. An unread word that has had no bits read is replaced by the newest result.
- R5: Bits leave most significant first. Each bit changes with a serial clock falling edge and holds through the following rising edge.
- R6: In master mode (`mode_sel`=0, `sclk_oe`=1), each word gets exactly 24 clock periods of `CLK_DIV` cycles, low half first. The clock then idles high.
- R7: In slave mode (`mode_sel`=1) `sclk_oe` is 0. The 24 host pulses may come in separate bursts, and the bit position is kept between bursts.
- R8: After the 24th rising edge the line returns to 1, and stays there until a new word is loaded.
- R9: A result that completes during a read does not disturb the word being read. The newest such result is loaded after the read ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select; low runs conversions |
| mode_sel | input | 1 | 0: block drives serial clock; 1: host drives it |
| conv_period | input | CW | Cycles per conversion (at least 2) |
| sclk_in | input | 1 | Host serial clock, slave mode |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| dout_rdy | output | 1 | Combined ready-low flag and serial data |
| dout_oe | output | 1 | Drive enable for `dout_rdy` |

## Verification
The first ready-low is due exactly `conv_period + 3` clocks after select falls: one clock for the pending flag, then the blanking window, then the load. The bench counts falling clock edges from the select edge to that point. In master mode the bench samples each bit at the falling system edge after the generated clock rises, requires successive rises `CLK_DIV` cycles apart, and expects the line and clock high two edges after the 24th rise. A host clock edge takes about three system cycles to act, so the slave reads hold each level ten cycles and sample just before releasing the clock high. The blanking window is measured by counting high cycles over one conversion period while a word sits unread.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BLANK = 2'd1,
    ST_READY = 2'd2
  } sh_state_t;
endpackage

// File: rtl/conv_timer.sv
// Abstract conversion engine: fires every `period` cycles while running and
// hands out the next word of an arithmetic test sequence.
module conv_timer #(
  parameter int          W    = 24,
  parameter int          CW   = 16,
  parameter logic [W-1:0] SEED = '0,
  parameter logic [W-1:0] STEP = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          done,
  output logic [W-1:0]  word
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  acc_q, acc_d;

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    done  = 1'b0;
    if (!run) begin
      cnt_d = '0;
      acc_d = SEED;
    end else if (cnt_q >= period - CW'(1)) begin
      done  = 1'b1;
      cnt_d = '0;
      acc_d = acc_q + STEP;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  assign word = acc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= SEED;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  // R1: deselecting restarts the sequence from its first word
  a_r1_seed_reload: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (acc_q == SEED && cnt_q == '0));
  // R2: a completion restarts the period count
  a_r2_period_restart: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cnt_q == '0));
endmodule

// File: rtl/sclk_gen.sv
// Serial clock generator for master mode: low half first, then high half.
module sclk_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic fall_s,
  output logic rise_s
);
  localparam int HALF = DIV / 2;
  localparam int PW   = $clog2(DIV);

  logic [PW-1:0] phase_q, phase_d;
  logic          sclk_q, sclk_d;

  assign fall_s = run && (phase_q == PW'(HALF - 1));
  assign rise_s = run && (phase_q == PW'(DIV - 1));

  always_comb begin
    phase_d = phase_q;
    sclk_d  = sclk_q;
    if (!run) begin
      phase_d = '0;
      sclk_d  = 1'b1;
    end else begin
      phase_d = rise_s ? '0 : phase_q + PW'(1);
      if (fall_s)      sclk_d = 1'b0;
      else if (rise_s) sclk_d = 1'b1;
    end
  end

  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      sclk_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      sclk_q  <= sclk_d;
    end
  end

  // R6: clock parks high whenever no word is being sent
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> sclk_q);
  // R6: a falling event is followed by the low half
  a_r6_low_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    fall_s |=> !sclk_q);
endmodule

// File: rtl/result_shifter.sv
// Holds the pending result, blanks the line before a load, and shifts the
// loaded word out on serial clock events.
module result_shifter
  import srp_pkg::*;
#(
  parameter int W         = 24,
  parameter int BLANK_CYC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         new_valid,
  input  logic [W-1:0] new_word,
  input  logic         fall_s,
  input  logic         rise_s,
  output logic         clk_req,
  output logic         dout
);
  localparam int CNTW = $clog2(W + 1);
  localparam int BW   = $clog2(BLANK_CYC + 1);

  sh_state_t      state_q, state_d;
  logic           pend_q, pend_d;
  logic [W-1:0]   pword_q, pword_d;
  logic [W-1:0]   shreg_q, shreg_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic [BW-1:0]  blank_q, blank_d;
  logic           dout_q, dout_d;
  logic           rise_seen_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    pword_d = pword_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    blank_d = blank_q;
    dout_d  = dout_q;
    if (!enable) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      cnt_d   = '0;
      blank_d = '0;
      dout_d  = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pend_q) begin
            state_d = ST_BLANK;
            blank_d = '0;
            dout_d  = 1'b1;
          end
        end
        ST_BLANK: begin
          if (blank_q == BW'(BLANK_CYC - 1)) begin
            state_d = ST_READY;
            shreg_d = pword_q;
            cnt_d   = '0;
            dout_d  = 1'b0;
            pend_d  = 1'b0;
          end else begin
            blank_d = blank_q + BW'(1);
          end
        end
        ST_READY: begin
          if (fall_s && cnt_q < CNTW'(W)) begin
            dout_d  = shreg_q[W-1];
            shreg_d = {shreg_q[W-2:0], 1'b0};
            cnt_d   = cnt_q + CNTW'(1);
          end else if (rise_seen_q && cnt_q == CNTW'(W)) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            dout_d  = 1'b1;
          end else if (pend_q && cnt_q == '0) begin
            state_d = ST_BLANK;
            blank_d = '0;
            dout_d  = 1'b1;
          end
        end
        default: state_d = ST_IDLE;
      endcase
      if (new_valid) begin
        pend_d  = 1'b1;
        pword_d = new_word;
      end
    end
  end

  assign clk_req = (state_q == ST_READY);
  assign dout    = dout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_q      <= 1'b0;
      cnt_q       <= '0;
      blank_q     <= '0;
      dout_q      <= 1'b1;
      rise_seen_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_q      <= pend_d;
      cnt_q       <= cnt_d;
      blank_q     <= blank_d;
      dout_q      <= dout_d;
      rise_seen_q <= rise_s;
    end
  end

  // data registers carry no reset; loads are qualified by the control state
  always_ff @(posedge clk) begin
    if (new_valid && enable) pword_q <= pword_d;
    shreg_q <= shreg_d;
  end

  a_r1_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state_q == ST_IDLE && !pend_q && dout_q));
  a_r3_load_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ST_BLANK && blank_q == BW'(BLANK_CYC - 1))
      |=> (!dout_q && state_q == ST_READY));
  a_r4_blank_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BLANK) |-> dout_q);
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(W));
  a_r9_no_load_midread: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && state_q == ST_READY && cnt_q != '0 && cnt_q != CNTW'(W))
      |=> (state_q != ST_BLANK));
endmodule

// File: rtl/serial_result_port.sv
module serial_result_port #(
  parameter int           W         = 24,
  parameter int           CW        = 16,
  parameter int           CLK_DIV   = 8,
  parameter int           BLANK_CYC = 2,
  parameter logic [W-1:0] SEED      = 24'hA5C30F,
  parameter logic [W-1:0] STEP      = 24'h13579B
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          mode_sel,
  input  logic [CW-1:0] conv_period,
  input  logic          sclk_in,
  output logic          sclk_out,
  output logic          sclk_oe,
  output logic          dout_rdy,
  output logic          dout_oe
);
  logic rst_meta_q, rst_sync_q;
  logic s1_q, s2_q, s3_q;
  logic selected, master;
  logic done, clk_req, m_run;
  logic [W-1:0] word;
  logic m_sclk, m_fall, m_rise;
  logic s_fall, s_rise, fall_ev, rise_ev;
  logic sh_dout;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  // host clock synchronizer and edge history
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= sclk_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign selected = !sel_n;
  assign master   = !mode_sel;
  assign s_fall   = s3_q && !s2_q;
  assign s_rise   = !s3_q && s2_q;
  assign fall_ev  = master ? m_fall : s_fall;
  assign rise_ev  = master ? m_rise : s_rise;
  assign m_run    = clk_req && master && selected;

  conv_timer #(.W(W), .CW(CW), .SEED(SEED), .STEP(STEP)) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .run(selected), .period(conv_period),
    .done(done), .word(word)
  );

  sclk_gen #(.DIV(CLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_sync_q), .run(m_run),
    .sclk(m_sclk), .fall_s(m_fall), .rise_s(m_rise)
  );

  result_shifter #(.W(W), .BLANK_CYC(BLANK_CYC)) u_shift (
    .clk(clk), .rst_n(rst_sync_q), .enable(selected),
    .new_valid(done), .new_word(word),
    .fall_s(fall_ev), .rise_s(rise_ev),
    .clk_req(clk_req), .dout(sh_dout)
  );

  assign sclk_out = (selected && master) ? m_sclk : 1'b1;
  assign sclk_oe  = selected && master;
  assign dout_rdy = selected ? sh_dout : 1'b1;
  assign dout_oe  = selected;
endmodule

// File: tb/tb_serial_result_port.sv
module tb_serial_result_port;
  localparam int W = 24, CW = 16, DIV = 8, BLK = 2, H = 10;
  localparam logic [23:0] SEED = 24'hA5C30F, STEP = 24'h13579B;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sel_n, mode_sel, sclk_in;
  logic [CW-1:0] conv_period;
  logic sclk_out, sclk_oe, dout_rdy, dout_oe;

  serial_result_port #(.W(W), .CW(CW), .CLK_DIV(DIV), .BLANK_CYC(BLK),
                       .SEED(SEED), .STEP(STEP)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .mode_sel(mode_sel),
    .conv_period(conv_period), .sclk_in(sclk_in), .sclk_out(sclk_out),
    .sclk_oe(sclk_oe), .dout_rdy(dout_rdy), .dout_oe(dout_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [23:0] exp_q[$];

  function automatic logic [23:0] word_at(int n);
    logic [23:0] r = SEED;
    for (int i = 0; i < n; i++) r = r + STEP;
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // master-mode monitor: collects bits at generated rising edges
  bit mon_en = 0;
  int frames = 0, nb = 0, since = 0, post = 0;
  logic prev_s = 1'b1;
  logic [23:0] sh = '0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (post > 0) begin
        post--;
        if (post == 0) begin
          check("R8 line high after word", dout_rdy, 1);
          check("R6 clock idles high", sclk_out, 1);
        end
      end
      since++;
      if (prev_s == 1'b0 && sclk_out == 1'b1) begin
        if (nb > 0) check("R6 clock period", since, DIV);
        since = 0;
        sh = {sh[22:0], dout_rdy};
        nb++;
        if (nb == W) begin
          nb = 0; frames++; post = 2;
          if (exp_q.size() == 0) check("R2 unexpected word", 1, 0);
          else check("R5 master word", sh, exp_q.pop_front());
        end
      end
    end
    prev_s = sclk_out;
  end

  task automatic wait_ready(int max, string tag);
    int t = 0;
    while (dout_rdy !== 1'b0 && t < max) begin
      @(negedge clk); t++;
    end
    check(tag, dout_rdy, 0);
  endtask

  task automatic slave_read(int grp, int gap, output logic [23:0] w);
    w = '0;
    for (int b = 0; b < W; b++) begin
      @(negedge clk) sclk_in = 1'b0;
      repeat (H) @(negedge clk);
      w = {w[22:0], dout_rdy};
      sclk_in = 1'b1;
      repeat (H) @(negedge clk);
      if (grp != 0 && (b % grp) == grp - 1 && b != W - 1)
        repeat (gap) @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [23:0] w;
    int lat, highs, k;
    bit clk_low_early;
    rst_n = 1'b0; sel_n = 1'b1; mode_sel = 1'b0; sclk_in = 1'b1;
    conv_period = 16'd400;
    repeat (4) @(negedge clk);
    check("R1 reset dout_oe", dout_oe, 0);
    check("R1 reset sclk_oe", sclk_oe, 0);
    check("R1 reset sclk_out", sclk_out, 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // master mode: latency, then four scoreboarded words
    for (int i = 0; i < 4; i++) exp_q.push_back(word_at(i));
    mon_en = 1;
    sel_n = 1'b0;
    lat = 0; clk_low_early = 0;
    do begin
      @(negedge clk); lat++;
      if (dout_rdy && !sclk_out) clk_low_early = 1;
    end while (dout_rdy !== 1'b0 && lat < 5000);
    check("R2 first result latency", lat, 400 + 3);
    check("R3 clock held high before result", clk_low_early, 0);
    check("R6 master drives clock", sclk_oe, 1);
    for (int t = 0; t < 3000 && frames < 4; t++) @(negedge clk);
    check("R6 master frames delivered", frames, 4);
    check("R2 scoreboard drained", exp_q.size(), 0);
    mon_en = 0;

    // abort in the middle of a word
    wait_ready(1000, "R3 master ready");
    repeat (50) @(negedge clk);
    sel_n = 1'b1;
    @(negedge clk);
    check("R1 abort dout_oe", dout_oe, 0);
    check("R1 abort sclk_oe", sclk_oe, 0);

    // slave mode, grouped read
    mode_sel = 1'b1; conv_period = 16'd3000;
    repeat (5) @(negedge clk);
    sel_n = 1'b0;
    @(negedge clk);
    check("R1 held word discarded", dout_rdy, 1);
    check("R7 slave leaves clock undriven", sclk_oe, 0);
    wait_ready(4000, "R3 slave ready");
    exp_q.push_back(word_at(0));
    slave_read(8, 100, w);
    check("R7 grouped read word", w, exp_q.pop_front());
    check("R8 line high after slave read", dout_rdy, 1);
    wait_ready(4000, "R3 second ready");
    slave_read(0, 0, w);
    check("R5 contiguous read word", w, word_at(1));

    // unread word replaced: measure blanking
    wait_ready(4000, "R3 third ready");
    highs = 0;
    for (int t = 0; t < 3100; t++) begin
      @(negedge clk);
      if (dout_rdy) highs++;
    end
    check("R4 blank width", highs, BLK);
    slave_read(0, 0, w);
    check("R4 newest word loaded", w, word_at(3));

    // results arrive during a slow read
    sel_n = 1'b1;
    @(negedge clk);
    conv_period = 16'd300;
    sel_n = 1'b0;
    wait_ready(1000, "R3 held-back ready");
    slave_read(8, 300, w);
    check("R9 word intact across completions", w, word_at(0));
    wait_ready(200, "R9 deferred load");
    slave_read(0, 0, w);
    k = -1;
    for (int i = 0; i < 40; i++) if (k < 0 && word_at(i) == w) k = i;
    check("R9 deferred word is a later result", (k >= 2), 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule